// File: doc/BRIEF.md
# Reed–Muller Coefficient Transform Unit

This block turns a reversible function, held as a permutation table, into the positive-polarity Reed–Muller coefficients of each of its output bits. The table has 2^NV entries of NV bits each. Entry i is the output word the function produces for input word i. For every output bit the block yields one coefficient per product term over uncomplemented inputs, and the constant term is included. These coefficients are the canonical XOR-of-products form that a reversible synthesis flow rewrites step by step.

The table is filled through a plain write port. A start pulse then takes a snapshot of the table into per-output coefficient vectors. The block runs one butterfly pass per clock, XORing the lower member of each index pair into the upper member. After the last pass it raises done for one cycle.

The results can be read at any time by output index and term index. A term count for each output is also available. The block reports two further conditions. It raises an identity flag when every output reduces to its own input variable alone, which is the stop test of such a synthesis flow. It raises a separate flag when the snapshot was not a permutation.

Top module: `rm_xform`

## Requirements
- R1: After reset busy, done, ident and perm_err are low, and every coefficient and term count reads 0.
- R2: While busy is low, a cycle with wr_en high stores wr_data at table entry wr_addr. A write presented while busy is high is dropped and never affects any later transform.
- R3: A start sampled while idle raises busy for exactly NV cycles. Done is high for one cycle, NV cycles after the start edge, at the same time busy falls. The transform uses the table as it stood before any write presented in the start cycle.
- R4: A start presented while busy is high is ignored: it neither restarts nor prolongs the run.
- R5: After done, with rd_out < NV, rd_coef is the coefficient of term rd_term in the expansion of output bit rd_out. Bit k of the table index and of the output word is variable k. Bit k set in rd_term means variable k appears in the product. Term 0 is the constant.
- R6: For NV = 3 and the table {1,0,7,2,3,4,5,6}, the terms are as follows. Output 0 has terms {0,1}. Output 1 has terms {2,4,5}. Output 2 has terms {2,3,5}.
- R7: rd_count is the number of nonzero coefficients of output rd_out.
- R8: From done until the next accepted start, ident is high exactly when perm_err is low and each output j has the single term 2^j. Ident is low while busy.
- R9: perm_err is set at an accepted start when two table entries are equal, and is cleared at an accepted start otherwise. While it is set, ident stays low.
- R10: An rd_out value of NV or more reads a coefficient of 0 and a count of 0.
- R11: Coefficients keep their values from done until the next accepted start, even when the table is rewritten meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | NV | Table entry index |
| wr_data | input | NV | Output word for that entry |
| start | input | 1 | Begin a transform |
| rd_out | input | max(1,clog2(NV)) | Output bit selector |
| rd_term | input | NV | Product term selector |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_coef | output | 1 | Selected coefficient |
| rd_count | output | NV+1 | Term count of selected output |
| ident | output | 1 | Function reduces to identity |
| perm_err | output | 1 | Snapshot was not a permutation |

## Verification
Two situations can put a table write and a transform request in the same cycle. In the first, a write is presented together with start while the block is idle. The snapshot must then hold the old entry, and the new entry must serve only the next run. In the second, a write or a second start is presented while a run is in progress, and both must be dropped. The bench provokes both cases on purpose and also mixes them into random permutation and non-permutation loads. A behavioural model tracks the table, the snapshot and the cycle count. It computes the expected coefficients as subset XOR sums over the snapshot, and it is compared with busy, done, the flags and the read port on every clock.

// File: rtl/rm_xform.sv
module rm_xform #(
  parameter int NV = 3,
  localparam int N  = 1 << NV,
  localparam int OW = (NV > 1) ? $clog2(NV) : 1,
  localparam int CW = NV + 1,
  localparam int PW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [NV-1:0] wr_addr,
  input  logic [NV-1:0] wr_data,
  input  logic          start,
  input  logic [OW-1:0] rd_out,
  input  logic [NV-1:0] rd_term,
  output logic          busy,
  output logic          done,
  output logic          rd_coef,
  output logic [CW-1:0] rd_count,
  output logic          ident,
  output logic          perm_err
);

  logic [N-1:0][NV-1:0] tbl;
  logic [NV-1:0][N-1:0] coef, snap, bfly;
  logic [PW-1:0]        pass;
  logic                 valid;
  logic [N-1:0]         seen;
  logic                 is_perm, all_unit;
  logic [N-1:0]         sel_vec;

  always_comb begin
    for (int j = 0; j < NV; j++)
      for (int i = 0; i < N; i++)
        snap[j][i] = tbl[i][j];
  end

  always_comb begin
    for (int j = 0; j < NV; j++)
      for (int i = 0; i < N; i++)
        if (((i >> pass) & 1) != 0)
          bfly[j][i] = coef[j][i] ^ coef[j][i ^ (1 << pass)];
        else
          bfly[j][i] = coef[j][i];
  end

  always_comb begin
    seen = '0;
    for (int i = 0; i < N; i++) seen[tbl[i]] = 1'b1;
  end
  assign is_perm = &seen;

  always_comb begin
    all_unit = 1'b1;
    for (int j = 0; j < NV; j++)
      if (coef[j] != (N'(1) << (1 << j))) all_unit = 1'b0;
  end
  assign ident = valid & ~perm_err & all_unit;

  assign sel_vec = (int'(rd_out) < NV) ? coef[rd_out] : '0;
  assign rd_coef = sel_vec[rd_term];

  always_comb begin
    rd_count = '0;
    for (int i = 0; i < N; i++) rd_count = rd_count + CW'(sel_vec[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl      <= '0;
      coef     <= '0;
      pass     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      valid    <= 1'b0;
      perm_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        coef <= bfly;
        if (pass == PW'(NV - 1)) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          valid <= 1'b1;
        end else begin
          pass <= pass + 1'b1;
        end
      end else if (start) begin
        coef     <= snap;
        pass     <= '0;
        busy     <= 1'b1;
        valid    <= 1'b0;
        perm_err <= ~is_perm;
      end
      if (wr_en && !busy) tbl[wr_addr] <= wr_data;
    end
  end

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  a_r3_pass_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> int'(pass) < NV);
  a_r4_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pass != PW'(NV - 1) |=> busy && !done);
  a_r2_tbl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tbl));
  a_r11_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(coef));
  a_r9_err_blocks_ident: assert property (@(posedge clk) disable iff (!rst_n)
    perm_err |-> !ident);
  a_r8_ident_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ident |-> !busy);

endmodule

// File: tb/sim_rm_xform.sv
module sim_rm_xform;
  localparam int NV = 3;
  localparam int N  = 1 << NV;
  localparam int OW = 2;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0;
  logic [NV-1:0] wr_addr = '0, wr_data = '0, rd_term = '0;
  logic [OW-1:0] rd_out = '0;
  logic busy, done, rd_coef, ident, perm_err;
  logic [NV:0] rd_count;

  int checks = 0, failures = 0, cyc = 0;

  rm_xform #(.NV(NV)) u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .start,
    .rd_out, .rd_term, .busy, .done, .rd_coef, .rd_count, .ident, .perm_err);

  always #5 clk = ~clk;

  int m_tbl[N], m_snap[N], m_coef[NV], m_cnt;
  bit m_busy, m_done, m_valid, m_perr;

  function automatic bit dup(int t[N]);
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++) if (t[a] == t[b]) return 1;
    return 0;
  endfunction

  function automatic bit m_ident();
    if (!m_valid || m_perr) return 0;
    for (int j = 0; j < NV; j++) if (m_coef[j] != (1 << (1 << j))) return 0;
    return 1;
  endfunction

  function automatic int m_read(int o, int t);
    if (o >= NV) return 0;
    return (m_coef[o] >> t) & 1;
  endfunction

  function automatic int m_pop(int o);
    int c = 0;
    if (o >= NV) return 0;
    for (int t = 0; t < N; t++) c += (m_coef[o] >> t) & 1;
    return c;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      foreach (m_tbl[i]) m_tbl[i] = 0;
      foreach (m_coef[j]) m_coef[j] = 0;
      m_busy = 0; m_done = 0; m_valid = 0; m_perr = 0; m_cnt = 0;
    end else begin
      automatic bit ob = m_busy;
      m_done = 0;
      if (ob) begin
        m_cnt++;
        if (m_cnt == NV) begin
          m_busy = 0; m_done = 1; m_valid = 1;
          for (int j = 0; j < NV; j++) begin
            m_coef[j] = 0;
            for (int t = 0; t < N; t++) begin
              automatic int c = 0;
              for (int i = 0; i < N; i++)
                if ((i & ~t) == 0) c ^= (m_snap[i] >> j) & 1;
              m_coef[j] |= c << t;
            end
          end
        end
      end else if (start) begin
        m_snap = m_tbl; m_busy = 1; m_cnt = 0; m_valid = 0;
        m_perr = dup(m_tbl);
      end
      if (wr_en && !ob) m_tbl[wr_addr] = int'(wr_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 busy", busy, m_busy);
      check("R3 done", done, m_done);
      check("R9 perm_err", perm_err, m_perr);
      check("R8 ident", ident, m_ident());
      if (!m_busy) begin
        check(int'(rd_out) >= NV ? "R10 coef" : "R5 coef", rd_coef, m_read(rd_out, rd_term));
        check(int'(rd_out) >= NV ? "R10 count" : "R7 count", rd_count, m_pop(rd_out));
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = NV'(a); wr_data = NV'(d); tick(); wr_en = 0;
  endtask

  task automatic go();
    start = 1; tick(); start = 0;
    while (!done) begin
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1; wr_addr = NV'($urandom); wr_data = NV'($urandom);
      end
      start = $urandom_range(0, 1);
      tick();
      wr_en = 0; start = 0;
    end
  endtask

  task automatic rd(int o, int t);
    rd_out = OW'(o); rd_term = NV'(t); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ex[N] = '{1, 0, 7, 2, 3, 4, 5, 6};
    int e0 = 'b11, e1 = (1<<2)|(1<<4)|(1<<5), e2 = (1<<2)|(1<<3)|(1<<5);
    repeat (3) tick();
    @(negedge clk);
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    check("R1 ident", ident, 0); check("R1 perm_err", perm_err, 0);
    check("R1 count", rd_count, 0);
    rst_n = 1; tick();

    for (int i = 0; i < N; i++) wr(i, ex[i]);
    start = 1; tick(); start = 0;
    while (!done) tick();
    for (int t = 0; t < N; t++) begin
      rd(0, t); check("R6 out0", rd_coef, (e0 >> t) & 1);
      rd(1, t); check("R6 out1", rd_coef, (e1 >> t) & 1);
      rd(2, t); check("R6 out2", rd_coef, (e2 >> t) & 1);
    end
    rd(1, 0); check("R7 out1 count", rd_count, 3);
    rd(3, 0); check("R10 high out count", rd_count, 0);
    tick();
    wr(0, 5);
    rd(0, 0); check("R11 hold after rewrite", rd_coef, 1);
    tick();

    for (int i = 0; i < N; i++) wr(i, i);
    start = 1; tick(); start = 0;
    wr(3, 3); start = 1; tick(); start = 0;
    while (!done) tick();
    @(negedge clk); check("R8 identity seen", ident, 1);
    tick();
    wr_en = 1; wr_addr = 3; wr_data = 0; start = 1; tick(); wr_en = 0; start = 0;
    @(negedge clk); check("R8 ident low while busy", ident, 0);
    while (!done) tick();
    @(negedge clk); check("R3 same-cycle write not in snapshot", ident, 1);
    tick();
    go();
    @(negedge clk); check("R9 duplicate flagged", perm_err, 1);
    check("R9 ident blocked", ident, 0);
    tick();

    for (int k = 0; k < 40; k++) begin
      int p[N];
      for (int i = 0; i < N; i++) p[i] = i;
      for (int i = N - 1; i > 0; i--) begin
        int r = $urandom_range(0, i), x = p[i];
        p[i] = p[r]; p[r] = x;
      end
      if (k % 5 == 4) p[$urandom_range(0, N-1)] = $urandom_range(0, N-1);
      for (int i = 0; i < N; i++) wr(i, p[i]);
      go();
      for (int s = 0; s < 12; s++) begin
        rd_out = OW'($urandom_range(0, 3)); rd_term = NV'($urandom);
        tick();
      end
    end
    repeat (2) tick();
    finish_run();
  end
endmodule